// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block sits on a continuous stream of 16-bit configuration words headed for a tiled programmable fabric and works out, for every word, where in the fabric it belongs. The stream is cut into frames of a fixed length. A three-part frame address (row, major column, minor frame) starts at the bottom-left corner and steps forward by itself at the end of each frame. The whole fabric can therefore be loaded as one unbroken stream, with no address written per frame.

Each major column has a type, taken from an elaboration-time column map, and the type sets how many minor frames that column holds. The minor counter wraps at that column's own count, not at one global modulus. Each accepted word comes out with its row, major, minor and word index. A word that falls inside a logic tile also comes out with its tile slot. The sequencer has two states. In ST_LOAD it takes words. The load-complete transition into ST_DONE is taken when the final word of the final frame of the top row is accepted. The restart transition back to ST_LOAD is taken on a start pulse from either state.

Top module: `cfg_frame_seq`

## Requirements
- R1: After synchronous reset, in_ready is 1, done is 0, and out_row, out_major, out_minor and out_word are all 0.
- R2: A frame is TILES_PER_FRAME*WORDS_PER_TILE+1 words long, which is 65 by default. out_word rises by one for each accepted word and returns to 0 after the word with index 64 is accepted.
- R3: For word indices 0 to 63, out_slot_valid is 1 and out_slot equals the word index divided by 4. For word index 64, out_slot_valid is 0.
- R4: When a frame ends, out_minor rises by one. If out_minor already equals the column's minor count minus 1, it returns to 0 and out_major rises by one. The type code of column c sits in COL_MAP bits [3c+2:3c]. The minor counts are: code 0 gives 31, code 1 gives 30, code 2 gives 25, code 3 gives 24, code 4 gives 30, code 5 gives 31, code 6 gives 30, and the reserved code 7 gives 30.
- R5: When a frame ends in the last minor of column NUM_COLS-1, out_major returns to 0 and out_row rises by one.
- R6: While loading, in_ready stays 1 (except during a start pulse). The address moves only on an accepted word, meaning in_valid and in_ready are both 1. out_valid marks each accepted word, and out_data carries that word.
- R7: done is 1 for exactly one cycle, in the cycle after the last word of the last row is accepted. From that cycle on, in_ready is 0 and every address output reads 0.
- R8: In ST_DONE, words offered on in_valid are refused. out_valid stays 0 and the address does not move until a start pulse arrives.
- R9: A start pulse in either state holds in_ready at 0 for that cycle. In the next cycle the address is back at 0 and in_ready is 1.
- R10: Reset asserted in the middle of a load clears every counter and the done flag, and loading resumes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse; returns the address to zero |
| in_valid | input | 1 | Configuration word offered |
| in_ready | output | 1 | Sequencer takes the offered word |
| in_data | input | DATA_W | Configuration word |
| out_valid | output | 1 | A word is accepted this cycle |
| out_data | output | DATA_W | The accepted word |
| out_row | output | ROW_W | Row of the current frame |
| out_major | output | MAJ_W | Major column of the current frame |
| out_minor | output | MIN_W | Minor frame within the column |
| out_word | output | WORD_W | Word index within the frame |
| out_slot | output | SLOT_W | Tile slot of the current word |
| out_slot_valid | output | 1 | Current word belongs to a tile |
| done | output | 1 | One-cycle pulse after the final word is accepted |

## Verification
The hardest condition to reach from the ports is the load-complete transition, along with the refusal of words that follows it. Both appear only after every frame of every column of every row has gone through. To reach them, the bench uses a two-row fabric that holds each of the seven column types once. It streams the full fabric twice, with a recurring idle gap in in_valid, and computes every expected row, major, minor and word from the index of the accepted word. Before the second pass, a restart and a reset arrive in the middle of the stream, so both are exercised away from the zero address.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        COL_MEMLOGIC = 3'd0,
        COL_ARITH    = 3'd1,
        COL_BRAM     = 3'd2,
        COL_DSP      = 3'd3,
        COL_EDGE_L   = 3'd4,
        COL_CENTER   = 3'd5,
        COL_EDGE_R   = 3'd6,
        COL_RSVD     = 3'd7
    } col_kind_e;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_DONE = 1'b1
    } seq_state_e;

    localparam int MAX_MINORS = 31;

    // Number of minor frames held by a column of the given kind.
    function automatic int unsigned kind_minors(input logic [KIND_W-1:0] kind);
        int unsigned n;
        unique case (col_kind_e'(kind))
            COL_MEMLOGIC: n = 31;
            COL_ARITH:    n = 30;
            COL_BRAM:     n = 25;
            COL_DSP:      n = 24;
            COL_EDGE_L:   n = 30;
            COL_CENTER:   n = 31;
            COL_EDGE_R:   n = 30;
            default:      n = 30;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cfg_col_lut.sv
module cfg_col_lut
    import cfg_frame_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int MAJ_W    = 3,
    parameter int MIN_W    = 5,
    parameter logic [NUM_COLS*KIND_W-1:0] COL_MAP = '0
) (
    input  logic [MAJ_W-1:0] major,
    output logic [MIN_W-1:0] last_minor
);

    logic [MIN_W-1:0] lim_tbl [NUM_COLS];

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam logic [KIND_W-1:0] KIND = COL_MAP[KIND_W*c +: KIND_W];
        assign lim_tbl[c] = MIN_W'(kind_minors(KIND) - 1);
    end

    always_comb begin
        last_minor = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (major == MAJ_W'(c)) last_minor = lim_tbl[c];
        end
    end

endmodule

// File: rtl/cfg_word_ctr.sv
module cfg_word_ctr #(
    parameter int TILES_PER_FRAME = 16,
    parameter int WORDS_PER_TILE  = 4,
    parameter int WORD_W          = 7,
    parameter int SLOT_W          = 4
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              clr,
    input  logic              adv,
    output logic [WORD_W-1:0] word,
    output logic              frame_end,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_valid
);

    localparam int TILE_WORDS  = TILES_PER_FRAME * WORDS_PER_TILE;
    localparam int FRAME_WORDS = TILE_WORDS + 1;

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            word <= '0;
        end else if (adv) begin
            if (word == WORD_W'(FRAME_WORDS - 1)) word <= '0;
            else                                   word <= word + 1'b1;
        end
    end

    always_comb begin
        frame_end  = (word == WORD_W'(FRAME_WORDS - 1));
        slot_valid = (word < WORD_W'(TILE_WORDS));
        slot       = slot_valid ? SLOT_W'(word / WORD_W'(WORDS_PER_TILE)) : '0;
    end

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 8,
    parameter int ROW_W    = 2,
    parameter int MAJ_W    = 3,
    parameter int MIN_W    = 5
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             clr,
    input  logic             step,
    input  logic [MIN_W-1:0] last_minor,
    output logic [ROW_W-1:0] row,
    output logic [MAJ_W-1:0] major,
    output logic [MIN_W-1:0] minor,
    output logic             addr_last
);

    logic minor_wrap;
    logic major_wrap;
    logic row_wrap;

    always_comb begin
        minor_wrap = (minor == last_minor);
        major_wrap = (major == MAJ_W'(NUM_COLS - 1));
        row_wrap   = (row == ROW_W'(NUM_ROWS - 1));
        addr_last  = minor_wrap && major_wrap && row_wrap;
    end

    always_ff @(posedge clk) begin
        if (srst || clr) begin
            row   <= '0;
            major <= '0;
            minor <= '0;
        end else if (step) begin
            if (!minor_wrap) begin
                minor <= minor + 1'b1;
            end else begin
                minor <= '0;
                if (!major_wrap) begin
                    major <= major + 1'b1;
                end else begin
                    major <= '0;
                    row   <= row_wrap ? '0 : row + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_frame_seq.sv
module cfg_frame_seq
    import cfg_frame_pkg::*;
#(
    parameter int NUM_ROWS        = 4,
    parameter int NUM_COLS        = 8,
    // column 0 in the low bits: edge-L, mem, arith, bram, center, mem, dsp, edge-R
    parameter logic [NUM_COLS*3-1:0] COL_MAP =
        {3'd6, 3'd3, 3'd0, 3'd5, 3'd2, 3'd1, 3'd0, 3'd4},
    parameter int TILES_PER_FRAME = 16,
    parameter int WORDS_PER_TILE  = 4,
    parameter int DATA_W          = 16,
    localparam int FRAME_WORDS = TILES_PER_FRAME * WORDS_PER_TILE + 1,
    localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int MAJ_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int MIN_W  = $clog2(MAX_MINORS + 1),
    localparam int WORD_W = $clog2(FRAME_WORDS),
    localparam int SLOT_W = (TILES_PER_FRAME > 1) ? $clog2(TILES_PER_FRAME) : 1
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [ROW_W-1:0]  out_row,
    output logic [MAJ_W-1:0]  out_major,
    output logic [MIN_W-1:0]  out_minor,
    output logic [WORD_W-1:0] out_word,
    output logic [SLOT_W-1:0] out_slot,
    output logic              out_slot_valid,
    output logic              done
);

    seq_state_e       state, state_nx;
    logic             done_q;
    logic             fire;
    logic             frame_end;
    logic             addr_last;
    logic             seq_last;
    logic [MIN_W-1:0] last_minor;

    cfg_word_ctr #(
        .TILES_PER_FRAME (TILES_PER_FRAME),
        .WORDS_PER_TILE  (WORDS_PER_TILE),
        .WORD_W          (WORD_W),
        .SLOT_W          (SLOT_W)
    ) u_word (
        .clk        (clk),
        .srst       (srst),
        .clr        (start),
        .adv        (fire),
        .word       (out_word),
        .frame_end  (frame_end),
        .slot       (out_slot),
        .slot_valid (out_slot_valid)
    );

    cfg_col_lut #(
        .NUM_COLS (NUM_COLS),
        .MAJ_W    (MAJ_W),
        .MIN_W    (MIN_W),
        .COL_MAP  (COL_MAP)
    ) u_lut (
        .major      (out_major),
        .last_minor (last_minor)
    );

    cfg_addr_ctr #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS),
        .ROW_W    (ROW_W),
        .MAJ_W    (MAJ_W),
        .MIN_W    (MIN_W)
    ) u_addr (
        .clk        (clk),
        .srst       (srst),
        .clr        (start),
        .step       (fire && frame_end),
        .last_minor (last_minor),
        .row        (out_row),
        .major      (out_major),
        .minor      (out_minor),
        .addr_last  (addr_last)
    );

    assign seq_last = frame_end && addr_last;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: if (!start && fire && seq_last) state_nx = ST_DONE;
            ST_DONE: if (start)                      state_nx = ST_LOAD;
            default:                                 state_nx = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) begin
            state  <= ST_LOAD;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= fire && seq_last;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state == ST_LOAD) && !start;
        fire      = in_valid && in_ready;
        out_valid = fire;
        out_data  = in_data;
        done      = done_q;
    end

endmodule

// File: rtl/cfg_frame_seq_chk.sv
module cfg_frame_seq_chk #(
    parameter int ROW_W       = 2,
    parameter int MAJ_W       = 3,
    parameter int MIN_W       = 5,
    parameter int WORD_W      = 7,
    parameter int FRAME_WORDS = 65
) (
    input logic              clk,
    input logic              srst,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ROW_W-1:0]  out_row,
    input logic [MAJ_W-1:0]  out_major,
    input logic [MIN_W-1:0]  out_minor,
    input logic [WORD_W-1:0] out_word,
    input logic [MIN_W-1:0]  last_minor,
    input logic              done
);

    logic acc;
    assign acc = in_valid && in_ready;

    assert_word_wrap_R2: assert property (@(posedge clk) disable iff (srst)
        acc && out_word == WORD_W'(FRAME_WORDS - 1) |=> out_word == '0);

    assert_word_step_R2: assert property (@(posedge clk) disable iff (srst)
        acc && out_word != WORD_W'(FRAME_WORDS - 1) |=> out_word == WORD_W'($past(out_word) + 1'b1));

    assert_minor_bound_R4: assert property (@(posedge clk) disable iff (srst)
        out_minor <= last_minor);

    assert_minor_step_R4: assert property (@(posedge clk) disable iff (srst)
        acc && out_word == WORD_W'(FRAME_WORDS - 1) && out_minor != last_minor
        |=> out_minor == MIN_W'($past(out_minor) + 1'b1) && $stable(out_major));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (srst)
        !acc && !start |=> $stable(out_word) && $stable(out_minor)
                           && $stable(out_major) && $stable(out_row));

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (srst)
        done |-> $past(acc));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (srst)
        done |=> !done);

    assert_refuse_after_done_R8: assert property (@(posedge clk) disable iff (srst)
        done |-> !in_ready);

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (srst)
        start |=> out_word == '0 && out_minor == '0 && out_major == '0 && out_row == '0);

endmodule

bind cfg_frame_seq cfg_frame_seq_chk #(
    .ROW_W       (ROW_W),
    .MAJ_W       (MAJ_W),
    .MIN_W       (MIN_W),
    .WORD_W      (WORD_W),
    .FRAME_WORDS (FRAME_WORDS)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .start      (start),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_row    (out_row),
    .out_major  (out_major),
    .out_minor  (out_minor),
    .out_word   (out_word),
    .last_minor (last_minor),
    .done       (done)
);

// File: tb/cfg_frame_seq_tb.sv
module cfg_frame_seq_tb;

    localparam int TB_ROWS = 2;
    localparam int TB_COLS = 7;
    localparam int FW      = 65;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic [0:0]  out_row;
    logic [2:0]  out_major;
    logic [4:0]  out_minor;
    logic [6:0]  out_word;
    logic [3:0]  out_slot;
    logic        out_slot_valid;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int kk    = 0;

    always #4 clk = ~clk;

    // column c carries type code c
    cfg_frame_seq #(
        .NUM_ROWS (TB_ROWS),
        .NUM_COLS (TB_COLS),
        .COL_MAP  ({3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0})
    ) u_dut (
        .clk (clk), .srst (srst), .start (start),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data),
        .out_row (out_row), .out_major (out_major), .out_minor (out_minor),
        .out_word (out_word), .out_slot (out_slot),
        .out_slot_valid (out_slot_valid), .done (done)
    );

    function automatic int minors_of(input int code);
        case (code)
            0: return 31;
            1: return 30;
            2: return 25;
            3: return 24;
            4: return 30;
            5: return 31;
            default: return 30;
        endcase
    endfunction

    function automatic int row_frames();
        int s = 0;
        for (int c = 0; c < TB_COLS; c++) s += minors_of(c);
        return s;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int k, output int r, output int mj, output int mn, output int w);
        int f;
        int rem;
        f   = k / FW;
        w   = k % FW;
        r   = f / row_frames();
        rem = f % row_frames();
        mj  = 0;
        while (rem >= minors_of(mj)) begin
            rem -= minors_of(mj);
            mj++;
        end
        mn = rem;
    endtask

    task automatic chk_zero(input string tag);
        chk(out_row == 0,   {tag, " row"},   out_row,   0);
        chk(out_major == 0, {tag, " major"}, out_major, 0);
        chk(out_minor == 0, {tag, " minor"}, out_minor, 0);
        chk(out_word == 0,  {tag, " word"},  out_word,  0);
    endtask

    // streams accepted words until kk reaches upto, with an idle gap every 7 cycles
    task automatic sweep(input int upto);
        int cyc;
        int r, mj, mn, w;
        cyc = 0;
        while (kk < upto) begin
            @(negedge clk);
            start    = 1'b0;
            in_valid = (cyc % 7) != 3;
            in_data  = 16'(kk * 7 + 3);
            cyc++;
            #1;
            model(kk, r, mj, mn, w);
            chk(out_row == r,    "R5 row",    out_row,   r);
            chk(out_major == mj, "R5 major",  out_major, mj);
            chk(out_minor == mn, "R4 minor",  out_minor, mn);
            chk(out_word == w,   "R2 word",   out_word,  w);
            chk(out_slot_valid == (w < 64), "R3 slot flag", out_slot_valid, (w < 64));
            if (w < 64) chk(out_slot == w / 4, "R3 slot", out_slot, w / 4);
            chk(in_ready == 1'b1, "R6 ready", in_ready, 1);
            chk(out_valid == in_valid, "R6 out_valid", out_valid, in_valid);
            if (in_valid) begin
                chk(out_data == in_data, "R6 data", out_data, in_data);
                kk++;
            end
            chk(done == 1'b0, "R7 no early done", done, 0);
        end
    endtask

    task automatic finish_load();
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(in_ready == 1'b0, "R7 ready low", in_ready, 0);
        chk_zero("R7 wrapped");
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(in_ready == 1'b0, "R7 ready stays low", in_ready, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", kk, 0);
        summary();
        $finish;
    end

    initial begin
        int total;
        total = TB_ROWS * row_frames() * FW;

        // R1 reset state
        repeat (3) @(negedge clk);
        srst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk_zero("R1");

        // partial load, then restart in the middle (R9)
        sweep(1000);
        @(negedge clk);
        start = 1'b1;
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R9 ready during start", in_ready, 0);
        chk(out_valid == 1'b0, "R9 no accept during start", out_valid, 0);
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9 ready after start", in_ready, 1);
        chk_zero("R9 cleared");
        kk = 0;

        // full load
        sweep(total);
        finish_load();

        // R8 refusal in ST_DONE
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            #1;
            chk(in_ready == 1'b0, "R8 ready", in_ready, 0);
            chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
            chk(done == 1'b0, "R8 done", done, 0);
            chk_zero("R8 address");
        end

        // restart from ST_DONE (R9)
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9 ready after restart", in_ready, 1);
        chk_zero("R9 restart");
        kk = 0;

        // mid-load reset (R10)
        sweep(300);
        @(negedge clk);
        in_valid = 1'b0;
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R10 ready", in_ready, 1);
        chk(done == 1'b0, "R10 done", done, 0);
        chk_zero("R10");
        kk = 0;

        sweep(total);
        finish_load();

        summary();
        $finish;
    end

endmodule